// File: doc/BRIEF.md
# I2C Message List Sequencer

This block walks a host-supplied list of I2C messages and drives a byte-level I2C master engine through the whole transfer, one command at a time, without host intervention. Each message descriptor gives a 7-bit target address, a direction flag, a flag that suppresses the repeated start in front of it, and a byte count. The sequencer forms the address byte and fetches outgoing data from a byte buffer. It writes incoming data back into the same buffer at consecutive positions. It picks ACK or NACK for every byte it reads, and it closes the transfer with a STOP command.

The host loads the descriptors and buffer, names the index of the last message and pulses `start_i`. While `busy_o` is high the sequencer reacts to every completion pulse from the byte engine. The transfer ends with exactly one of `done_o`, `error_o` or `timeout_o`, which holds until the next accepted start. Buffer data for all messages is packed back to back from buffer address 0.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `error_o`, `timeout_o`, `cmd_valid_o` and `buf_we_o` are all 0.
- R2: An accepted start issues a START command (code 0) whose byte is the message-0 address shifted left by one, with bit 0 set to 1 for a read and 0 for a write. The first message always gets a START, even when its no-start flag is set.
- R3: A write byte goes out as a WRITE command (code 1) carrying the buffer byte at the running buffer position, and the position then advances by one. Positions carry over from message to message.
- R4: A completion that reports arbitration loss, on any command other than the STOP, produces a STOP command (code 4). The transfer then ends with `error_o`.
- R5: A completion that reports NACK after a START or a WRITE produces a STOP command. The transfer then ends with `error_o`. A NACK flag on a read completion is ignored.
- R6: Each read completion writes `eng_rdata_i` into the buffer at the running position through `buf_we_o`, and the position then advances by one.
- R7: A read byte is requested with code 3 (read, then NACK) when it is the last byte of its message, and with code 2 (read, then ACK) otherwise.
- R8: When a message ends and more remain, the next message starts with a repeated START and its address byte if its no-start flag is clear. If the flag is set, its bytes follow directly in its own direction.
- R9: After the last message a STOP is issued. The completion of that STOP drops `busy_o` and raises `done_o`.
- R10: If the transfer is still busy `tmo_limit_i` cycles after it was accepted, `busy_o` drops and `timeout_o` rises. No further command is issued, and later completions change nothing.
- R11: A message of length 0 issues no data command. The sequencer moves on to the next message, or to the STOP, right after the address phase.
- R12: A start pulse while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a new transfer |
| last_msg_i | input | IDX_W | Index of the last message in the list |
| tmo_limit_i | input | TO_W | Timeout limit in clock cycles |
| desc_idx_o | output | IDX_W | Index of the descriptor being read |
| desc_addr_i | input | 7 | Target address of the indexed message |
| desc_rd_i | input | 1 | 1 = read message, 0 = write message |
| desc_nostart_i | input | 1 | Suppress the repeated start before this message |
| desc_len_i | input | LEN_W | Byte count of the indexed message |
| buf_addr_o | output | PTR_W | Byte buffer position |
| buf_we_o | output | 1 | Buffer write strobe for a received byte |
| buf_wdata_o | output | 8 | Received byte to store |
| buf_rdata_i | input | 8 | Buffer byte at `buf_addr_o` (combinational read) |
| cmd_valid_o | output | 1 | One-cycle command strobe to the byte engine |
| cmd_code_o | output | 3 | 0 START+byte, 1 WRITE, 2 READ+ACK, 3 READ+NACK, 4 STOP |
| cmd_byte_o | output | 8 | Address or data byte for START and WRITE |
| eng_done_i | input | 1 | Byte engine completion pulse |
| eng_nack_i | input | 1 | Target did not acknowledge (valid with `eng_done_i`) |
| eng_arb_i | input | 1 | Arbitration lost (valid with `eng_done_i`) |
| eng_rdata_i | input | 8 | Received byte (valid with `eng_done_i`) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Last transfer finished normally |
| error_o | output | 1 | Last transfer ended on NACK or arbitration loss |
| timeout_o | output | 1 | Last transfer hit the timeout |

## Verification
The hardest cases to reach are faults that land on one particular completion. Examples are arbitration loss in the middle of a read, or a NACK on the address of a later message after a repeated start. Reaching them also requires mixing no-start continuations with zero-length messages. The bench's byte engine model counts the commands it receives and injects the NACK or arbitration fault on a chosen command number. It can also go silent on a chosen command to force the timeout. Random message lists then put those faults against every message shape, and directed runs pin down the exact corners.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [2:0] {
    CMD_START   = 3'd0,
    CMD_WRITE   = 3'd1,
    CMD_RD_ACK  = 3'd2,
    CMD_RD_NACK = 3'd3,
    CMD_STOP    = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_NEXT  = 3'd1,
    M_START = 3'd2,
    M_WRITE = 3'd3,
    M_READ  = 3'd4,
    M_DONE  = 3'd5,
    M_ERROR = 3'd6
  } mode_e;

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction

endpackage

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            run_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expire_o
);
  logic [TO_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = clr_i || (run_i && (cnt_q != limit_i));
    cnt_d  = clr_i ? '0 : cnt_q + TO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = run_i && !clr_i && (cnt_q == limit_i);
endmodule

// File: rtl/i2cseq_cmdreg.sv
module i2cseq_cmdreg
  import i2cseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  cmd_e       code_i,
  input  logic [7:0] byte_i,
  output logic       valid_o,
  output logic [2:0] code_o,
  output logic [7:0] byte_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= go_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= 3'(CMD_STOP);
      byte_o <= '0;
    end else if (go_i) begin
      code_o <= 3'(code_i);
      byte_o <= byte_i;
    end
  end
endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int LEN_W = 8,
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] last_msg_i,
  input  logic             tmo_hit_i,
  output logic             accept_o,
  output logic [IDX_W-1:0] idx_o,
  input  logic [6:0]       d_addr_i,
  input  logic             d_rd_i,
  input  logic             d_nostart_i,
  input  logic [LEN_W-1:0] d_len_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             buf_we_o,
  input  logic [7:0]       buf_rdata_i,
  output logic             go_o,
  output cmd_e             code_o,
  output logic [7:0]       byte_o,
  input  logic             eng_done_i,
  input  logic             eng_nack_i,
  input  logic             eng_arb_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o,
  output logic             timeout_o
);
  mode_e            mode_q, mode_d;
  logic             issue_q, issue_d, first_q, first_d;
  logic             busy_q, busy_d, done_q, done_d, err_q, err_d, tmo_q, tmo_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_q, last_d;
  logic [LEN_W-1:0] pos_q, pos_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             msg_end, final_byte;
  mode_e            dir_mode;

  assign msg_end    = (pos_q == d_len_i);
  assign final_byte = ((pos_q + LEN_W'(1)) == d_len_i);
  assign dir_mode   = d_rd_i ? M_READ : M_WRITE;

  always_comb begin
    mode_d = mode_q;  issue_d = issue_q; first_d = first_q;
    busy_d = busy_q;  done_d  = done_q;  err_d   = err_q;  tmo_d = tmo_q;
    idx_d  = idx_q;   last_d  = last_q;  pos_d   = pos_q;  ptr_d = ptr_q;
    go_o = 1'b0; code_o = CMD_STOP; byte_o = '0; buf_we_o = 1'b0; accept_o = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        accept_o = 1'b1;
        busy_d = 1'b1; done_d = 1'b0; err_d = 1'b0; tmo_d = 1'b0;
        mode_d = M_NEXT; issue_d = 1'b1; first_d = 1'b1;
        idx_d = '0; pos_d = '0; ptr_d = '0; last_d = last_msg_i;
      end
    end else if (tmo_hit_i) begin
      busy_d = 1'b0; tmo_d = 1'b1; mode_d = M_IDLE; issue_d = 1'b0;
    end else if (issue_q) begin
      unique case (mode_q)
        M_NEXT: begin
          if (first_q || !d_nostart_i) begin
            go_o = 1'b1; code_o = CMD_START; byte_o = addr_byte(d_addr_i, d_rd_i);
            mode_d = M_START; issue_d = 1'b0; first_d = 1'b0;
          end else begin
            mode_d = dir_mode;
          end
        end
        M_WRITE, M_READ: begin
          if (msg_end) begin
            if (idx_q == last_q) begin
              go_o = 1'b1; code_o = CMD_STOP; mode_d = M_DONE; issue_d = 1'b0;
            end else begin
              idx_d = idx_q + IDX_W'(1); pos_d = '0; mode_d = M_NEXT;
            end
          end else if (mode_q == M_READ) begin
            go_o = 1'b1; code_o = final_byte ? CMD_RD_NACK : CMD_RD_ACK; issue_d = 1'b0;
          end else begin
            go_o = 1'b1; code_o = CMD_WRITE; byte_o = buf_rdata_i; issue_d = 1'b0;
            pos_d = pos_q + LEN_W'(1); ptr_d = ptr_q + PTR_W'(1);
          end
        end
        default: issue_d = 1'b0;
      endcase
    end else if (eng_done_i) begin
      unique case (mode_q)
        M_DONE:  begin busy_d = 1'b0; done_d = 1'b1; mode_d = M_IDLE; end
        M_ERROR: begin busy_d = 1'b0; err_d  = 1'b1; mode_d = M_IDLE; end
        M_START, M_WRITE: begin
          if (eng_arb_i || eng_nack_i) begin
            go_o = 1'b1; code_o = CMD_STOP; mode_d = M_ERROR;
          end else begin
            mode_d = (mode_q == M_START) ? dir_mode : M_WRITE; issue_d = 1'b1;
          end
        end
        M_READ: begin
          if (eng_arb_i) begin
            go_o = 1'b1; code_o = CMD_STOP; mode_d = M_ERROR;
          end else begin
            buf_we_o = 1'b1; issue_d = 1'b1;
            pos_d = pos_q + LEN_W'(1); ptr_d = ptr_q + PTR_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_IDLE; issue_q <= 1'b0; first_q <= 1'b0;
      busy_q <= 1'b0;   done_q  <= 1'b0; err_q   <= 1'b0; tmo_q <= 1'b0;
      idx_q  <= '0;     last_q  <= '0;   pos_q   <= '0;   ptr_q <= '0;
    end else begin
      mode_q <= mode_d; issue_q <= issue_d; first_q <= first_d;
      busy_q <= busy_d; done_q  <= done_d;  err_q   <= err_d;  tmo_q <= tmo_d;
      idx_q  <= idx_d;  last_q  <= last_d;  pos_q   <= pos_d;  ptr_q <= ptr_d;
    end
  end

  assign idx_o     = idx_q;
  assign ptr_o     = ptr_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign error_o   = err_q;
  assign timeout_o = tmo_q;
endmodule

// File: rtl/i2c_msg_sequencer.sv
module i2c_msg_sequencer
  import i2cseq_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int LEN_W = 8,
  parameter int PTR_W = 10,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] last_msg_i,
  input  logic [TO_W-1:0]  tmo_limit_i,
  output logic [IDX_W-1:0] desc_idx_o,
  input  logic [6:0]       desc_addr_i,
  input  logic             desc_rd_i,
  input  logic             desc_nostart_i,
  input  logic [LEN_W-1:0] desc_len_i,
  output logic [PTR_W-1:0] buf_addr_o,
  output logic             buf_we_o,
  output logic [7:0]       buf_wdata_o,
  input  logic [7:0]       buf_rdata_i,
  output logic             cmd_valid_o,
  output logic [2:0]       cmd_code_o,
  output logic [7:0]       cmd_byte_o,
  input  logic             eng_done_i,
  input  logic             eng_nack_i,
  input  logic             eng_arb_i,
  input  logic [7:0]       eng_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o,
  output logic             timeout_o
);
  logic       accept, tmo_hit, go;
  cmd_e       code;
  logic [7:0] cbyte;

  i2cseq_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(accept), .run_i(busy_o),
    .limit_i(tmo_limit_i), .expire_o(tmo_hit)
  );

  i2cseq_ctrl #(.IDX_W(IDX_W), .LEN_W(LEN_W), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_msg_i(last_msg_i),
    .tmo_hit_i(tmo_hit), .accept_o(accept), .idx_o(desc_idx_o),
    .d_addr_i(desc_addr_i), .d_rd_i(desc_rd_i), .d_nostart_i(desc_nostart_i),
    .d_len_i(desc_len_i), .ptr_o(buf_addr_o), .buf_we_o(buf_we_o),
    .buf_rdata_i(buf_rdata_i), .go_o(go), .code_o(code), .byte_o(cbyte),
    .eng_done_i(eng_done_i), .eng_nack_i(eng_nack_i), .eng_arb_i(eng_arb_i),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .timeout_o(timeout_o)
  );

  i2cseq_cmdreg u_cmd (
    .clk(clk), .rst_n(rst_n), .go_i(go), .code_i(code), .byte_i(cbyte),
    .valid_o(cmd_valid_o), .code_o(cmd_code_o), .byte_o(cmd_byte_o)
  );

  assign buf_wdata_o = eng_rdata_i;
endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid_o,
  input logic [2:0] cmd_code_o,
  input logic       eng_done_i,
  input logic       eng_nack_i,
  input logic       eng_arb_i,
  input logic       buf_we_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       error_o,
  input logic       timeout_o
);
  logic [2:0] last_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           last_code <= 3'd0;
    else if (cmd_valid_o) last_code <= cmd_code_o;
  end

  // R4
  arb_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && eng_done_i && eng_arb_i && last_code != 3'd4)
      |=> ((cmd_valid_o && cmd_code_o == 3'd4) || timeout_o));

  // R5
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && eng_done_i && eng_nack_i && (last_code == 3'd0 || last_code == 3'd1))
      |=> ((cmd_valid_o && cmd_code_o == 3'd4) || timeout_o));

  // R9
  final_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && eng_done_i && last_code == 3'd4) |=> !busy_o);

  // R9
  one_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, error_o, timeout_o}));

  // R10
  tmo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (!busy_o && !cmd_valid_o));

  // R6
  store_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we_o |-> busy_o);
endmodule

bind i2c_msg_sequencer i2cseq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o),
  .eng_done_i(eng_done_i), .eng_nack_i(eng_nack_i), .eng_arb_i(eng_arb_i),
  .buf_we_o(buf_we_o), .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
  .timeout_o(timeout_o)
);

// File: tb/i2c_msg_sequencer_bench.sv
module i2c_msg_sequencer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start_i = 1'b0;
  logic [2:0]  last_msg_i = '0;
  logic [15:0] tmo_limit_i = 16'd5000;
  logic [2:0]  desc_idx_o;
  logic [6:0]  desc_addr_i;
  logic        desc_rd_i, desc_nostart_i;
  logic [7:0]  desc_len_i;
  logic [9:0]  buf_addr_o;
  logic        buf_we_o;
  logic [7:0]  buf_wdata_o, buf_rdata_i;
  logic        cmd_valid_o;
  logic [2:0]  cmd_code_o;
  logic [7:0]  cmd_byte_o;
  logic        eng_done_i = 1'b0, eng_nack_i = 1'b0, eng_arb_i = 1'b0;
  logic [7:0]  eng_rdata_i = '0;
  logic        busy_o, done_o, error_o, timeout_o;

  logic [6:0] d_addr [0:7];
  logic       d_rd   [0:7];
  logic       d_ns   [0:7];
  logic [7:0] d_len  [0:7];
  logic [7:0] mem     [0:63];
  logic [7:0] exp_mem [0:63];
  logic [2:0] log_code [0:63];
  logic [7:0] log_byte [0:63];
  logic [2:0] exp_code [0:63];
  logic [7:0] exp_byte [0:63];
  int n_log = 0, n_exp = 0;
  int f_idx = -1, f_kind = 0, h_idx = -1;
  bit exp_err = 0;
  bit late_pulse = 0;
  int tests = 0, fails = 0;
  int cyc = 0;

  assign desc_addr_i    = d_addr[desc_idx_o];
  assign desc_rd_i      = d_rd[desc_idx_o];
  assign desc_nostart_i = d_ns[desc_idx_o];
  assign desc_len_i     = d_len[desc_idx_o];
  assign buf_rdata_i    = mem[buf_addr_o[5:0]];

  always @(posedge clk) if (buf_we_o) mem[buf_addr_o[5:0]] <= buf_wdata_o;

  i2c_msg_sequencer u_i2c_msg_sequencer (.*);

  function automatic logic [7:0] rdf(input int k);
    return 8'(k * 37 + 11) ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // engine model: logs commands, answers after 1..3 cycles, injects faults
  initial begin
    int cur, dly;
    bit pend;
    pend = 0; cur = 0; dly = 0;
    forever begin
      @(negedge clk);
      eng_done_i = 0; eng_nack_i = 0; eng_arb_i = 0;
      if (cmd_valid_o) begin
        cur = n_log;
        if (n_log < 64) begin
          log_code[n_log] = cmd_code_o; log_byte[n_log] = cmd_byte_o; n_log++;
        end
        pend = (cur != h_idx);
        dly  = $urandom_range(1, 3);
        if (cmd_code_o == 3'd4) dly = 1;
      end else if (pend) begin
        if (dly == 0) begin
          eng_done_i  = 1;
          eng_rdata_i = rdf(cur);
          if (cur == f_idx && log_code[cur] != 3'd4) begin
            eng_nack_i = (f_kind == 1);
            eng_arb_i  = (f_kind == 2);
          end
          pend = 0;
        end else dly--;
      end else if (late_pulse) begin
        eng_done_i = 1; late_pulse = 0;
      end
    end
  end

  task automatic push(input logic [2:0] c, input logic [7:0] b);
    exp_code[n_exp] = c; exp_byte[n_exp] = b; n_exp++;
  endtask

  function automatic bit faulted(input int k, input bit nackable);
    return (k == f_idx) && (f_kind == 2 || (f_kind == 1 && nackable));
  endfunction

  task automatic build_expect(input int last);
    int p;
    bit ab;
    p = 0; ab = 0; n_exp = 0; exp_err = 0;
    for (int m = 0; m <= last && !ab; m++) begin
      if (m == 0 || !d_ns[m]) begin
        push(3'd0, {d_addr[m], d_rd[m]});
        if (faulted(n_exp - 1, 1)) ab = 1;
      end
      for (int i = 0; i < int'(d_len[m]) && !ab; i++) begin
        if (d_rd[m]) begin
          push((i == int'(d_len[m]) - 1) ? 3'd3 : 3'd2, 8'h00);
          if (faulted(n_exp - 1, 0)) ab = 1;
          else begin exp_mem[p] = rdf(n_exp - 1); p++; end
        end else begin
          push(3'd1, exp_mem[p]); p++;
          if (faulted(n_exp - 1, 1)) ab = 1;
        end
      end
    end
    push(3'd4, 8'h00);
    exp_err = ab;
  endtask

  task automatic run_xfer(input int last, input string tag, input bit restart);
    int w;
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'($urandom); exp_mem[i] = mem[i];
    end
    build_expect(last);
    n_log = 0;
    last_msg_i = 3'(last);
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    w = 0;
    while (busy_o && w < 5000) begin
      @(negedge clk); w++;
      if (restart && w == 6) start_i = 1;
      if (restart && w == 7) start_i = 0;
    end
    start_i = 0;
    check(!busy_o, {tag, " end of transfer"}, busy_o, 0);
    if (h_idx >= 0) return;
    check(n_log == n_exp, {tag, " command count"}, n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      string rq;
      case (exp_code[i])
        3'd0: rq = "R2/R8";
        3'd1: rq = "R3";
        3'd4: rq = "R9/R4/R5";
        default: rq = "R7";
      endcase
      check(log_code[i] == exp_code[i], {tag, " ", rq, " code"}, log_code[i], exp_code[i]);
      if (exp_code[i] <= 3'd1)
        check(log_byte[i] == exp_byte[i], {tag, " ", rq, " byte"}, log_byte[i], exp_byte[i]);
    end
    if (exp_err)
      check(error_o && !done_o && !timeout_o, {tag, " R4/R5 error status"},
            {done_o, error_o, timeout_o}, 3'b010);
    else
      check(done_o && !error_o && !timeout_o, {tag, " R9 done status"},
            {done_o, error_o, timeout_o}, 3'b100);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) bad++;
      check(bad == 0, {tag, " R6 buffer contents"}, bad, 0);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic set_msg(input int m, input logic [6:0] a, input bit rd, input bit ns, input int len);
    d_addr[m] = a; d_rd[m] = rd; d_ns[m] = ns; d_len[m] = 8'(len);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) set_msg(i, 7'h00, 0, 0, 0);
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy_o, done_o, error_o, timeout_o, cmd_valid_o, buf_we_o} == 6'b0,
          "R1 reset outputs", {busy_o, done_o, error_o, timeout_o, cmd_valid_o, buf_we_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 plain write
    f_idx = -1; f_kind = 0; h_idx = -1;
    set_msg(0, 7'h2C, 0, 0, 2);
    run_xfer(0, "write2", 0);
    // R7 read with NACK on last byte
    set_msg(0, 7'h51, 1, 1, 3);
    run_xfer(0, "read3 R7", 0);
    // R11 zero-length write then read
    set_msg(0, 7'h11, 0, 0, 0);
    set_msg(1, 7'h12, 1, 0, 1);
    run_xfer(1, "zerolen R11", 0);
    check(n_log == 4, "R11 no data command for empty message", n_log, 4);
    // R8 no-start continuation across direction change, then repeated start
    set_msg(0, 7'h33, 0, 0, 2);
    set_msg(1, 7'h34, 1, 1, 2);
    set_msg(2, 7'h35, 0, 0, 1);
    run_xfer(2, "chain R8", 0);
    check(n_log == 8, "R8 command count with one suppressed start", n_log, 8);
    // R5 NACK on address of second message after repeated start
    set_msg(0, 7'h40, 0, 0, 1);
    set_msg(1, 7'h41, 0, 0, 2);
    f_idx = 2; f_kind = 1;
    run_xfer(1, "nack addr R5", 0);
    // R5 NACK flag on a read completion is ignored
    set_msg(0, 7'h42, 1, 0, 3);
    f_idx = 1; f_kind = 1;
    run_xfer(0, "nack on read R5", 0);
    // R4 arbitration loss during read
    set_msg(0, 7'h43, 1, 0, 4);
    f_idx = 2; f_kind = 2;
    run_xfer(0, "arb read R4", 0);
    // R12 start while busy ignored
    set_msg(0, 7'h44, 0, 0, 4);
    set_msg(1, 7'h45, 1, 0, 2);
    f_idx = -1; f_kind = 0;
    run_xfer(1, "restart R12", 1);

    // R10 timeout with a silent engine
    set_msg(0, 7'h46, 0, 0, 3);
    tmo_limit_i = 16'd40; h_idx = 1;
    run_xfer(0, "timeout R10", 0);
    check(timeout_o && !done_o && !error_o, "R10 timeout status",
          {done_o, error_o, timeout_o}, 3'b001);
    check(n_log == 2, "R10 commands before timeout", n_log, 2);
    late_pulse = 1;
    repeat (6) @(negedge clk);
    check(n_log == 2 && timeout_o && !busy_o, "R10 late completion ignored", n_log, 2);
    h_idx = -1; tmo_limit_i = 16'd5000;

    // random message lists with random faults
    for (int r = 0; r < 40; r++) begin
      int last, k;
      last = $urandom_range(0, 3);
      for (int m = 0; m <= last; m++)
        set_msg(m, 7'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0),
                $urandom_range(0, 5));
      k = $urandom_range(0, 9);
      f_kind = (k < 6) ? 0 : (k < 8) ? 1 : 2;
      f_idx  = (f_kind == 0) ? -1 : $urandom_range(0, 12);
      run_xfer(last, "random", 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end
endmodule